// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a processor subsystem. A 12-bit down-counter advances once every PRESCALE periods of a slow timebase. The slow timebase arrives as a one-cycle strobe `slow_tick` in the bus clock domain. Software keeps the counter from running out by writing a keyed restart command. If the counter reaches zero, the block latches an underflow flag. It can then raise a fault interrupt and a one-cycle reset request.

A restart that arrives too early is latched as a window error and escalated in the same way. Too early means the counter is still above a programmed window value. Counting can be suspended while the system is in a debug state or an idle state, and each of the two is enabled separately.

Every write to the control or mode register is held as pending for SYNC_TICKS slow ticks before it acts. The `busy` output is high for that whole interval. Any write that lands while `busy` is high is discarded. A status read returns the pending flags one cycle after the read strobe and clears them.

Top module: `wdt_timer`

## Requirements
- R1: After reset the mode register reads 0x0FFF0FFF, the status register reads 0, and `busy`, `irq` and `rst_req` are low. The mode value means reload 0xFFF, window 0xFFF, enabled, and no interrupt, reset or halt enables.
- R2: A control-register write (address 0) starts a restart only if bits 31:24 equal 0xA5 and bit 0 is 1. Any other control write leaves `busy` low and changes neither the timeout nor the status.
- R3: An accepted write raises `busy` from the next cycle. `busy` stays high for SYNC_TICKS slow ticks, and the write acts on the edge of the last of them. A control or mode write made while `busy` is high is dropped.
- R4: After a reload to value N with counting enabled, an underflow occurs (N+1)×PRESCALE slow ticks later. The underflow sets status bit 0 and reloads the counter from the reload field.
- R5: `rst_req` is a single-cycle pulse. It is issued on an underflow or a window error only when mode bit 13 (reset enable) is 1.
- R6: `irq` is high exactly while a status flag is pending and mode bit 12 (interrupt enable) is 1.
- R7: A keyed restart that takes effect while the counter is above the window field (mode bits 27:16) sets status bit 1. A restart that takes effect at or below the window sets nothing.
- R8: While mode bit 15 (disable) is 1, the counter holds and restarts are ignored. A mode write that has bit 15 set updates every field except reload (bits 11:0) and window (bits 27:16).
- R9: A mode write that has bit 15 clear reloads the counter with the new reload value, as a restart does.
- R10: Counting pauses while `dbg_halt` is high and mode bit 28 is 1, or while `idle_halt` is high and mode bit 29 is 1. A halt input whose enable bit is 0 has no effect.
- R11: A read strobe puts the addressed register on `bus_rdata` after the next clock edge. The register map is mode at address 1 and status at address 2. A status read clears both flags, and a flag raised in the same cycle as the read takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow timebase period |
| dbg_halt | input | 1 | System is in debug state |
| idle_halt | input | 1 | System is in idle state |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| busy | output | 1 | A register write is still synchronizing |
| irq | output | 1 | Fault interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
An error in the counter or the prescaler shows up as a timeout that is off by whole multiples of PRESCALE ticks. The bench therefore measures each timeout from the cycle `busy` falls, to the exact cycle. An error in the window comparison shows up at once on `rst_req`, on the edge where the restart applies. That is why restarts are placed on the two sides of the window boundary. A wrong synchronizer state shows up as a `busy` interval that is too long or too short, or as a dropped write that still takes effect, and the next timeout measurement exposes it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int              WDT_CNT_W       = 12;
    localparam logic [7:0]      WDT_RESTART_KEY = 8'hA5;

    typedef enum logic [1:0] {
        WDT_REG_CTRL = 2'd0,
        WDT_REG_MODE = 2'd1,
        WDT_REG_STAT = 2'd2,
        WDT_REG_NONE = 2'd3
    } wdt_reg_e;

    typedef enum logic [1:0] {
        PEND_IDLE = 2'd0,
        PEND_KICK = 2'd1,
        PEND_MODE = 2'd2
    } wdt_pend_e;

    // Decoded mode register; field order is independent of the bus word.
    typedef struct packed {
        logic                 idle_stop;
        logic                 dbg_stop;
        logic [WDT_CNT_W-1:0] window;
        logic                 off;
        logic                 rst_en;
        logic                 irq_en;
        logic [WDT_CNT_W-1:0] reload;
    } wdt_mode_t;

    typedef struct packed {
        logic win_err;
        logic uflow;
    } wdt_stat_t;

    localparam wdt_mode_t WDT_MODE_RST = '{
        idle_stop: 1'b0,
        dbg_stop:  1'b0,
        window:    12'hFFF,
        off:       1'b0,
        rst_en:    1'b0,
        irq_en:    1'b0,
        reload:    12'hFFF
    };

    // Bus word layout: reload 11:0, irq_en 12, rst_en 13, off 15,
    // window 27:16, dbg_stop 28, idle_stop 29.
    function automatic logic [31:0] mode_to_word(wdt_mode_t m);
        return {2'b00, m.idle_stop, m.dbg_stop, m.window, m.off, 1'b0,
                m.rst_en, m.irq_en, m.reload};
    endfunction

    function automatic logic [31:0] stat_to_word(wdt_stat_t s);
        return {30'd0, s.win_err, s.uflow};
    endfunction

endpackage

// File: rtl/wdt_wsync.sv
module wdt_wsync
    import wdt_pkg::*;
#(
    parameter int SYNC_TICKS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      slow_tick,
    input  logic      req_kick,
    input  logic      req_mode,
    input  wdt_mode_t req_word,
    output logic      busy_o,
    output logic      apply_kick_o,
    output logic      apply_mode_o,
    output wdt_mode_t held_o
);
    localparam int              CW   = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0]   LAST = CW'(SYNC_TICKS - 1);

    wdt_pend_e          pend_q;
    logic [CW-1:0]      cnt_q;
    wdt_mode_t          held_q;
    logic               fire;

    assign fire = (pend_q != PEND_IDLE) && slow_tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= PEND_IDLE;
            cnt_q  <= '0;
            held_q <= WDT_MODE_RST;
        end else if (pend_q == PEND_IDLE) begin
            cnt_q <= '0;
            if (req_kick) begin
                pend_q <= PEND_KICK;
            end else if (req_mode) begin
                pend_q <= PEND_MODE;
                held_q <= req_word;
            end
        end else if (slow_tick) begin
            if (cnt_q == LAST) begin
                pend_q <= PEND_IDLE;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o       = (pend_q != PEND_IDLE);
    assign apply_kick_o = fire && (pend_q == PEND_KICK);
    assign apply_mode_o = fire && (pend_q == PEND_MODE);
    assign held_o       = held_q;

    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> $past(slow_tick)); // R3

endmodule

// File: rtl/wdt_presc.sv
module wdt_presc #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_tick,
    input  logic run_i,
    input  logic clear_i,
    output logic dec_o
);
    localparam int            PW   = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            div_q <= '0;
        end else if (run_i && slow_tick) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign dec_o = run_i && slow_tick && (div_q == LAST);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      apply_kick,
    input  logic      apply_mode,
    input  wdt_mode_t new_mode,
    input  logic      dec_tick,
    input  logic      run_i,
    input  logic      stat_clr,
    output wdt_mode_t mode_o,
    output wdt_stat_t stat_o,
    output logic      rst_req_o,
    output logic      restart_o
);
    wdt_mode_t              mode_q;
    wdt_mode_t              mode_nx;
    wdt_stat_t              stat_q;
    logic [WDT_CNT_W-1:0]   count_q;
    logic                   rst_req_q;
    logic                   kick_live;
    logic                   kick_early;
    logic                   wrap;

    // A disabling write keeps the old reload and window.
    always_comb begin
        mode_nx = new_mode;
        if (new_mode.off) begin
            mode_nx.reload = mode_q.reload;
            mode_nx.window = mode_q.window;
        end
    end

    assign kick_live  = apply_kick && !mode_q.off;
    assign kick_early = kick_live && (count_q > mode_q.window);
    assign wrap       = dec_tick && (count_q == '0) && !apply_mode && !kick_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= WDT_MODE_RST;
            count_q   <= {WDT_CNT_W{1'b1}};
            stat_q    <= '0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (apply_mode) begin
                mode_q <= mode_nx;
                if (!new_mode.off) begin
                    count_q <= new_mode.reload;
                end
            end else if (kick_live) begin
                count_q <= mode_q.reload;
                if (kick_early && mode_q.rst_en) begin
                    rst_req_q <= 1'b1;
                end
            end else if (dec_tick) begin
                if (count_q == '0) begin
                    count_q   <= mode_q.reload;
                    rst_req_q <= mode_q.rst_en;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            stat_q.uflow   <= wrap | (stat_q.uflow & ~stat_clr);
            stat_q.win_err <= kick_early | (stat_q.win_err & ~stat_clr);
        end
    end

    assign mode_o    = mode_q;
    assign stat_o    = stat_q;
    assign rst_req_o = rst_req_q;
    assign restart_o = (apply_mode && !new_mode.off) || kick_live || wrap;

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst) rst_req_q |=> !rst_req_q); // R5
    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) rst_req_q |-> $past(mode_q.rst_en)); // R5
    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst) (!run_i && !apply_mode && !apply_kick) |=> $stable(count_q)); // R8
    AST_UFLOW_FROM_TICK: assert property (@(posedge clk) disable iff (rst) $rose(stat_q.uflow) |-> $past(dec_tick)); // R4

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRESCALE   = 128,
    parameter int SYNC_TICKS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic        dbg_halt,
    input  logic        idle_halt,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic        irq,
    output logic        rst_req
);
    wdt_reg_e   sel;
    wdt_mode_t  word_mode;
    wdt_mode_t  held_mode;
    wdt_mode_t  mode_q;
    wdt_stat_t  stat_q;
    logic       req_kick;
    logic       req_mode;
    logic       apply_kick;
    logic       apply_mode;
    logic       dec_tick;
    logic       restart;
    logic       halted;
    logic       run;
    logic       stat_clr;
    logic [31:0] rdata_q;
    logic       unused_wbits;

    assign sel = wdt_reg_e'(bus_addr);

    always_comb begin
        word_mode.reload    = bus_wdata[11:0];
        word_mode.irq_en    = bus_wdata[12];
        word_mode.rst_en    = bus_wdata[13];
        word_mode.off       = bus_wdata[15];
        word_mode.window    = bus_wdata[27:16];
        word_mode.dbg_stop  = bus_wdata[28];
        word_mode.idle_stop = bus_wdata[29];
    end
    assign unused_wbits = ^{bus_wdata[31:30], bus_wdata[14]};

    assign req_kick = bus_we && (sel == WDT_REG_CTRL)
                      && (bus_wdata[31:24] == WDT_RESTART_KEY) && bus_wdata[0];
    assign req_mode = bus_we && (sel == WDT_REG_MODE);
    assign stat_clr = bus_re && (sel == WDT_REG_STAT);

    assign halted = (dbg_halt && mode_q.dbg_stop) || (idle_halt && mode_q.idle_stop);
    assign run    = !mode_q.off && !halted;

    wdt_wsync #(.SYNC_TICKS(SYNC_TICKS)) u_wsync (
        .clk          (clk),
        .rst          (rst),
        .slow_tick    (slow_tick),
        .req_kick     (req_kick),
        .req_mode     (req_mode),
        .req_word     (word_mode),
        .busy_o       (busy),
        .apply_kick_o (apply_kick),
        .apply_mode_o (apply_mode),
        .held_o       (held_mode)
    );

    wdt_presc #(.PRESCALE(PRESCALE)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .run_i     (run),
        .clear_i   (restart),
        .dec_o     (dec_tick)
    );

    wdt_core u_core (
        .clk        (clk),
        .rst        (rst),
        .apply_kick (apply_kick),
        .apply_mode (apply_mode),
        .new_mode   (held_mode),
        .dec_tick   (dec_tick),
        .run_i      (run),
        .stat_clr   (stat_clr),
        .mode_o     (mode_q),
        .stat_o     (stat_q),
        .rst_req_o  (rst_req),
        .restart_o  (restart)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            case (sel)
                WDT_REG_MODE: rdata_q <= mode_to_word(mode_q);
                WDT_REG_STAT: rdata_q <= stat_to_word(stat_q);
                default:      rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = mode_q.irq_en && (stat_q.uflow || stat_q.win_err);

    AST_UNKEYED_IGNORED: assert property (@(posedge clk) disable iff (rst) (bus_we && bus_addr == 2'd0 && !busy && !(bus_wdata[31:24] == 8'hA5 && bus_wdata[0])) |=> !busy); // R2

endmodule

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        idle_halt = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;
    logic        irq;
    logic        rst_req;

    wdt_timer #(.PRESCALE(P), .SYNC_TICKS(3)) dut_i (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
        .idle_halt(idle_halt), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .busy(busy), .irq(irq),
        .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] mask_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;
    always @(posedge clk) rd_pend <= re;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: pops one expected item per completed read.
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read data", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                logic [31:0] m;
                string       t;
                e = exp_q.pop_front();
                m = mask_q.pop_front();
                t = tag_q.pop_front();
                if (m != 0) check((rdata & m) == (e & m), t, rdata, e);
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] e, logic [31:0] m, string t);
        exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic next_pulse(int limit, output int at);
        int t0 = cyc;
        forever begin
            @(negedge clk);
            if (rst_req || (cyc - t0) >= limit) break;
        end
        at = cyc;
    endtask

    task automatic count_pulses(int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) k++;
        end
    endtask

    initial begin
        int t0;
        int t1;
        int at;
        int k;
        int n;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
        rd(2'd1, 32'h0FFF0FFF, 32'hFFFFFFFF, "R1 mode reset value");
        rd(2'd2, 32'h0, 32'hFFFFFFFF, "R1 status reset value");

        // R3/R9/R4: busy span and timeout after mode reload 9
        wr(2'd1, 32'h0FFF3009);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == 3, "R3 busy span in ticks", n, 3);
        t0 = cyc;
        next_pulse(200, at);
        check(at - t0 == 40, "R4 R9 timeout reload 9", at - t0, 40);
        check(irq == 1'b1, "R6 irq on underflow", irq, 1);
        @(negedge clk);
        check(rst_req == 1'b0, "R5 reset request is one cycle", rst_req, 0);
        rd(2'd2, 32'h1, 32'hFFFFFFFF, "R4 underflow flag");
        rd(2'd2, 32'h0, 32'hFFFFFFFF, "R11 status cleared by read");
        check(irq == 1'b0, "R11 irq low after clear", irq, 0);

        // R3: write during busy is dropped
        wr(2'd1, 32'h0FFF3009);
        wr(2'd1, 32'h0FFF301D);
        wait_idle();
        t0 = cyc;
        next_pulse(400, at);
        check(at - t0 == 40, "R3 second write dropped", at - t0, 40);

        // R2: unkeyed control writes ignored; keyed restart accepted
        wr(2'd1, 32'h0FFF3009);
        wait_idle();
        t0 = cyc;
        rd(2'd2, 32'h0, 32'h0, "clear");
        wr(2'd0, 32'h5A000001);
        check(busy == 1'b0, "R2 wrong key ignored", busy, 0);
        wr(2'd0, 32'hA5000000);
        check(busy == 1'b0, "R2 missing bit 0 ignored", busy, 0);
        next_pulse(200, at);
        check(at - t0 == 40, "R2 timeout unchanged", at - t0, 40);
        @(negedge clk);
        wr(2'd0, 32'hA5000001);
        check(busy == 1'b1, "R2 keyed restart accepted", busy, 1);
        wait_idle();
        t1 = cyc;
        rd(2'd2, 32'h1, 32'hFFFFFFFF, "R2 no window error at window 0xFFF");
        next_pulse(200, at);
        check(at - t1 == 40, "R2 restart reloads", at - t1, 40);

        // R7: window boundary, reload 19 window 5
        wr(2'd1, 32'h00053013);
        wait_idle();
        t0 = cyc;
        rd(2'd2, 32'h0, 32'h0, "clear");
        wait_to(t0 + 50);
        wr(2'd0, 32'hA5000001);
        wait_idle();
        t1 = cyc;
        check(t1 - t0 == 54, "R3 restart apply cycle", t1 - t0, 54);
        check(rst_req == 1'b1, "R7 early restart reset pulse", rst_req, 1);
        check(irq == 1'b1, "R6 irq on window error", irq, 1);
        rd(2'd2, 32'h2, 32'hFFFFFFFF, "R7 window error flag");
        wait_to(t1 + 54);
        wr(2'd0, 32'hA5000001);
        wait_idle();
        check(rst_req == 1'b0, "R7 restart at window value accepted", rst_req, 0);
        rd(2'd2, 32'h0, 32'hFFFFFFFF, "R7 no error at window value");

        // R8: disabled watchdog
        wr(2'd1, 32'h0007B00A);
        wait_idle();
        rd(2'd2, 32'h0, 32'h0, "clear");
        count_pulses(200, k);
        check(k == 0, "R8 no timeout while disabled", k, 0);
        rd(2'd1, 32'h0005B013, 32'hFFFFFFFF, "R8 reload/window kept while disabled");
        wr(2'd0, 32'hA5000001);
        wait_idle();
        rd(2'd2, 32'h0, 32'hFFFFFFFF, "R8 restart ignored while disabled");
        wr(2'd1, 32'h00003003);
        wait_idle();
        t0 = cyc;
        next_pulse(100, at);
        check(at - t0 == 16, "R9 enable reloads", at - t0, 16);

        // R10: debug and idle halts
        dbg_halt = 1'b1;
        wr(2'd1, 32'h1FFF2003);
        wait_idle();
        count_pulses(100, k);
        check(k == 0, "R10 debug halt stops counting", k, 0);
        dbg_halt = 1'b0;
        t0 = cyc;
        next_pulse(100, at);
        check(at - t0 == 16, "R10 resume after debug halt", at - t0, 16);
        idle_halt = 1'b1;
        wr(2'd1, 32'h0FFF2003);
        wait_idle();
        t0 = cyc;
        next_pulse(100, at);
        check(at - t0 == 16, "R10 idle input without enable", at - t0, 16);
        wr(2'd1, 32'h2FFF2003);
        wait_idle();
        count_pulses(100, k);
        check(k == 0, "R10 idle halt stops counting", k, 0);
        idle_halt = 1'b0;
        t0 = cyc;
        next_pulse(100, at);
        check(at - t0 == 16, "R10 resume after idle halt", at - t0, 16);

        // R5/R6: reset enable clear, interrupt enable clear
        wr(2'd1, 32'h0FFF1003);
        wait_idle();
        rd(2'd2, 32'h0, 32'h0, "clear");
        count_pulses(60, k);
        check(k == 0, "R5 no reset request without enable", k, 0);
        check(irq == 1'b1, "R6 irq with enable", irq, 1);
        rd(2'd2, 32'h1, 32'hFFFFFFFF, "R4 underflow with irq only");
        wr(2'd1, 32'h0FFF0003);
        wait_idle();
        count_pulses(40, k);
        check(irq == 1'b0, "R6 irq gated off", irq, 0);
        rd(2'd2, 32'h1, 32'hFFFFFFFF, "R6 flag pending while gated");

        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule